// File: doc/BRIEF.md
# Path-Compressed Trie Longest-Prefix Lookup

This block resolves a destination address to a next-hop code by longest-prefix match. It walks a path-compressed binary trie held in a small internal node table, one node per clock. Every node stores a prefix (MSB-aligned, with a length), an optional next-hop code, the address bit it branches on, and two child indices. Chains of one-child nodes without routes are assumed to be already collapsed by the table builder. Because of that, a single step can skip several address bits. Whenever a node's prefix disagrees with the address, the walk ends at once.

Software or a control agent fills the table through a simple one-cycle write port. Lookups arrive on a valid/ready request channel. When a walk ends, the block returns a one-cycle response pulse that carries a hit flag and a next-hop code. The deepest matching route seen on the path wins. When no route matched, the block returns a configurable default code with the hit flag low. Index 0 acts as the null child, and the walk always starts at a fixed root index.

Top module: `pct_lookup`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `rsp_hit` is 0 and `rsp_nh` equals `DEFAULT_NH`.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 for the whole walk, and any request presented during a walk is ignored: it neither changes the pending result nor produces a response of its own.
- R3: Bit positions count from the address MSB, so position p tests address bit `ADDR_W-1-p`. A tested bit of 0 follows the left child and a tested bit of 1 follows the right child.
- R4: A node is matched when the top `plen` bits of its stored prefix equal the top `plen` bits of the address (a length of 0 always matches). A matched node that carries a next hop replaces the recorded best result, so the deepest matching route is returned.
- R5: On reaching a node whose prefix does not match, the walk stops and reports the best result recorded before that node.
- R6: When the selected child index is 0, the walk stops without visiting another node and reports the best result so far.
- R7: If no route matched on the path, the response has `rsp_hit` = 0 and `rsp_nh` = `DEFAULT_NH`.
- R8: The engine visits exactly one node per cycle, so the cycle count from acceptance to response equals the number of nodes visited. The count never exceeds `ADDR_W`, even on a table that contains a loop.
- R9: `rsp_valid` is high for exactly one cycle per accepted request, and `rsp_hit`/`rsp_nh` hold their values until the next response.
- R10: A write stores all fields of node `wr_idx` in one cycle, and later lookups use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Node write strobe |
| wr_idx | input | IDX_W | Node index to write |
| wr_prefix | input | ADDR_W | Prefix bits, MSB-aligned |
| wr_plen | input | LEN_W | Prefix length in bits (0..ADDR_W) |
| wr_has_nh | input | 1 | Node carries a next hop |
| wr_nh | input | NH_W | Next-hop code of the node |
| wr_bitpos | input | POS_W | Branch bit position, counted from MSB |
| wr_left | input | IDX_W | Child index taken on bit 0 (0 = none) |
| wr_right | input | IDX_W | Child index taken on bit 1 (0 = none) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | ADDR_W | Address to resolve |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_hit | output | 1 | A route matched |
| rsp_nh | output | NH_W | Resolved next hop, or DEFAULT_NH on a miss |

## Verification
The bench builds the engine with 8-bit addresses, a 16-entry node table, 4-bit next-hop codes, root at index 1 and a default code of 15, which differs from every route code used. The short address width puts the full `ADDR_W`-visit cap within a few cycles, so a deliberately looped node can show the bound being enforced. The table has only a handful of nodes, so a single eight-entry vector set reaches the cases of a skipped-bit branch, a mid-path prefix mismatch, a null child, the deepest leaf and a total miss.

// File: rtl/pct_pkg.sv
`timescale 1ns/1ps
package pct_pkg;

    // Walk controller states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_e;

    // Child index value meaning "no child"
    localparam int unsigned NULL_IDX = 0;

endpackage

// File: rtl/pct_node_mem.sv
`timescale 1ns/1ps
module pct_node_mem #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NODE_CNT = 16,
    parameter int unsigned NH_W     = 4,
    localparam int unsigned IDX_W   = $clog2(NODE_CNT),
    localparam int unsigned POS_W   = $clog2(ADDR_W),
    localparam int unsigned LEN_W   = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_prefix,
    input  logic [LEN_W-1:0]  wr_plen,
    input  logic              wr_has_nh,
    input  logic [NH_W-1:0]   wr_nh,
    input  logic [POS_W-1:0]  wr_bitpos,
    input  logic [IDX_W-1:0]  wr_left,
    input  logic [IDX_W-1:0]  wr_right,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_prefix,
    output logic [LEN_W-1:0]  rd_plen,
    output logic              rd_has_nh,
    output logic [NH_W-1:0]   rd_nh,
    output logic [POS_W-1:0]  rd_bitpos,
    output logic [IDX_W-1:0]  rd_left,
    output logic [IDX_W-1:0]  rd_right
);
    logic [ADDR_W-1:0] t_prefix [NODE_CNT];
    logic [LEN_W-1:0]  t_plen   [NODE_CNT];
    logic              t_has    [NODE_CNT];
    logic [NH_W-1:0]   t_nh     [NODE_CNT];
    logic [POS_W-1:0]  t_pos    [NODE_CNT];
    logic [IDX_W-1:0]  t_left   [NODE_CNT];
    logic [IDX_W-1:0]  t_right  [NODE_CNT];

    // Reset clears all links, so an unloaded table is a set of dead ends
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NODE_CNT; i++) begin
                t_prefix[i] <= '0;
                t_plen[i]   <= '0;
                t_has[i]    <= 1'b0;
                t_nh[i]     <= '0;
                t_pos[i]    <= '0;
                t_left[i]   <= '0;
                t_right[i]  <= '0;
            end
        end else if (wr_en) begin
            t_prefix[wr_idx] <= wr_prefix;
            t_plen[wr_idx]   <= wr_plen;
            t_has[wr_idx]    <= wr_has_nh;
            t_nh[wr_idx]     <= wr_nh;
            t_pos[wr_idx]    <= wr_bitpos;
            t_left[wr_idx]   <= wr_left;
            t_right[wr_idx]  <= wr_right;
        end
    end

    // Asynchronous read: one node per cycle without a read stage
    assign rd_prefix = t_prefix[rd_idx];
    assign rd_plen   = t_plen[rd_idx];
    assign rd_has_nh = t_has[rd_idx];
    assign rd_nh     = t_nh[rd_idx];
    assign rd_bitpos = t_pos[rd_idx];
    assign rd_left   = t_left[rd_idx];
    assign rd_right  = t_right[rd_idx];
endmodule

// File: rtl/pct_node_eval.sv
`timescale 1ns/1ps
module pct_node_eval #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NODE_CNT = 16,
    localparam int unsigned IDX_W   = $clog2(NODE_CNT),
    localparam int unsigned POS_W   = $clog2(ADDR_W),
    localparam int unsigned LEN_W   = $clog2(ADDR_W + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] prefix,
    input  logic [LEN_W-1:0]  plen,
    input  logic [POS_W-1:0]  bitpos,
    input  logic [IDX_W-1:0]  left,
    input  logic [IDX_W-1:0]  right,
    output logic              match,
    output logic [IDX_W-1:0]  child
);
    logic [ADDR_W-1:0] lead_mask;
    logic [ADDR_W-1:0] addr_rev;

    // Position 0 is the address MSB
    for (genvar g = 0; g < ADDR_W; g++) begin : g_rev
        assign addr_rev[g] = addr[ADDR_W-1-g];
    end

    assign lead_mask = ~({ADDR_W{1'b1}} >> plen);
    assign match     = ((addr ^ prefix) & lead_mask) == '0;
    assign child     = addr_rev[bitpos] ? right : left;
endmodule

// File: rtl/pct_walker.sv
`timescale 1ns/1ps
module pct_walker
    import pct_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NODE_CNT   = 16,
    parameter int unsigned NH_W       = 4,
    parameter int unsigned ROOT_IDX   = 1,
    parameter logic [NH_W-1:0] DEFAULT_NH = '0,
    localparam int unsigned IDX_W     = $clog2(NODE_CNT),
    localparam int unsigned CNT_W     = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [ADDR_W-1:0] addr_q,
    output logic [IDX_W-1:0]  cur_idx,
    input  logic              node_match,
    input  logic              node_has_nh,
    input  logic [NH_W-1:0]   node_nh,
    input  logic [IDX_W-1:0]  node_child,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [NH_W-1:0]   rsp_nh
);
    localparam logic [CNT_W-1:0] LAST_VISIT = CNT_W'(ADDR_W - 1);

    walk_state_e      state;
    logic [CNT_W-1:0] visits;
    logic             best_ok;
    logic [NH_W-1:0]  best_nh;
    logic             take, hit_nx, stop;
    logic [NH_W-1:0]  nh_nx;

    assign req_ready = (state == ST_IDLE);
    assign take      = node_match && node_has_nh;
    assign hit_nx    = best_ok || take;
    assign nh_nx     = take ? node_nh : best_nh;
    assign stop      = !node_match || (node_child == IDX_W'(NULL_IDX))
                       || (visits == LAST_VISIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            cur_idx   <= '0;
            visits    <= '0;
            best_ok   <= 1'b0;
            best_nh   <= DEFAULT_NH;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_nh    <= DEFAULT_NH;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        cur_idx <= IDX_W'(ROOT_IDX);
                        visits  <= '0;
                        best_ok <= 1'b0;
                        best_nh <= DEFAULT_NH;
                        state   <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    best_ok <= hit_nx;
                    best_nh <= nh_nx;
                    visits  <= visits + 1'b1;
                    cur_idx <= node_child;
                    if (stop) begin
                        state     <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_hit   <= hit_nx;
                        rsp_nh    <= hit_nx ? nh_nx : DEFAULT_NH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_WALK_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WALK) |-> (visits < CNT_W'(ADDR_W))); // R8
    AST_NO_NULL_VISIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WALK) |-> (cur_idx != IDX_W'(NULL_IDX))); // R6
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R9
    AST_MISS_CODE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_nh == DEFAULT_NH)); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_WALK) && $past(state == ST_WALK)) |-> $stable(addr_q)); // R2
    AST_RSP_HELD: assert property (@(posedge clk) disable iff (rst)
        (!rsp_valid && !$past(rst)) |-> ($stable(rsp_nh) && $stable(rsp_hit))); // R9
endmodule

// File: rtl/pct_lookup.sv
`timescale 1ns/1ps
module pct_lookup #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NODE_CNT   = 16,
    parameter int unsigned NH_W       = 4,
    parameter int unsigned ROOT_IDX   = 1,
    parameter logic [NH_W-1:0] DEFAULT_NH = '0,
    localparam int unsigned IDX_W     = $clog2(NODE_CNT),
    localparam int unsigned POS_W     = $clog2(ADDR_W),
    localparam int unsigned LEN_W     = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_prefix,
    input  logic [LEN_W-1:0]  wr_plen,
    input  logic              wr_has_nh,
    input  logic [NH_W-1:0]   wr_nh,
    input  logic [POS_W-1:0]  wr_bitpos,
    input  logic [IDX_W-1:0]  wr_left,
    input  logic [IDX_W-1:0]  wr_right,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [NH_W-1:0]   rsp_nh
);
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] n_prefix;
    logic [LEN_W-1:0]  n_plen;
    logic              n_has;
    logic [NH_W-1:0]   n_nh;
    logic [POS_W-1:0]  n_pos;
    logic [IDX_W-1:0]  n_left, n_right, n_child;
    logic              n_match;

    pct_node_mem #(.ADDR_W(ADDR_W), .NODE_CNT(NODE_CNT), .NH_W(NH_W)) u_mem (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_prefix(wr_prefix), .wr_plen(wr_plen),
        .wr_has_nh(wr_has_nh), .wr_nh(wr_nh), .wr_bitpos(wr_bitpos),
        .wr_left(wr_left), .wr_right(wr_right),
        .rd_idx(cur_idx), .rd_prefix(n_prefix), .rd_plen(n_plen),
        .rd_has_nh(n_has), .rd_nh(n_nh), .rd_bitpos(n_pos),
        .rd_left(n_left), .rd_right(n_right)
    );

    pct_node_eval #(.ADDR_W(ADDR_W), .NODE_CNT(NODE_CNT)) u_eval (
        .addr(addr_q), .prefix(n_prefix), .plen(n_plen), .bitpos(n_pos),
        .left(n_left), .right(n_right), .match(n_match), .child(n_child)
    );

    pct_walker #(.ADDR_W(ADDR_W), .NODE_CNT(NODE_CNT), .NH_W(NH_W),
                 .ROOT_IDX(ROOT_IDX), .DEFAULT_NH(DEFAULT_NH)) u_walk (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .addr_q(addr_q), .cur_idx(cur_idx),
        .node_match(n_match), .node_has_nh(n_has), .node_nh(n_nh),
        .node_child(n_child),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_nh(rsp_nh)
    );
endmodule

// File: tb/pct_lookup_test.sv
`timescale 1ns/1ps
module pct_lookup_test;
    localparam int AW = 8;
    localparam int NC = 16;
    localparam int NW = 4;
    localparam logic [3:0] DEF = 4'hF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [7:0] wr_prefix = '0;
    logic [3:0] wr_plen = '0;
    logic       wr_has_nh = 1'b0;
    logic [3:0] wr_nh = '0;
    logic [2:0] wr_bitpos = '0;
    logic [3:0] wr_left = '0;
    logic [3:0] wr_right = '0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [7:0] req_addr = '0;
    logic       rsp_valid, rsp_hit;
    logic [3:0] rsp_nh;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pct_lookup #(.ADDR_W(AW), .NODE_CNT(NC), .NH_W(NW), .ROOT_IDX(1),
                 .DEFAULT_NH(DEF)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_prefix(wr_prefix), .wr_plen(wr_plen), .wr_has_nh(wr_has_nh),
        .wr_nh(wr_nh), .wr_bitpos(wr_bitpos), .wr_left(wr_left),
        .wr_right(wr_right), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_nh(rsp_nh)
    );

    // {address, expected hit, expected next hop}
    localparam logic [12:0] VECS [8] = '{
        {8'h35, 1'b1, 4'd1},   // left branch, leaf "0"            R3 R6
        {8'h9A, 1'b1, 4'd2},   // "1011" mismatches 1001           R5
        {8'hB3, 1'b1, 4'd4},   // deepest leaf "101100"            R4
        {8'hB8, 1'b1, 4'd3},   // null right child under "1011"    R6
        {8'hB4, 1'b1, 4'd3},   // leaf "101100" mismatches         R5
        {8'h8F, 1'b1, 4'd6},   // skipped bit, left to "10001"     R3 R4
        {8'h87, 1'b1, 4'd2},   // "10001" mismatches 10000         R5
        {8'hC0, 1'b0, DEF}     // "10" mismatches 11, no route     R7
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put_node(input logic [3:0] idx, input logic [7:0] pfx,
                            input logic [3:0] len, input logic has,
                            input logic [3:0] nh, input logic [2:0] pos,
                            input logic [3:0] lt, input logic [3:0] rt);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_prefix = pfx; wr_plen = len;
        wr_has_nh = has; wr_nh = nh; wr_bitpos = pos; wr_left = lt; wr_right = rt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Returns result and cycles from acceptance edge to response
    task automatic lookup(input logic [7:0] a, output logic hit,
                          output logic [3:0] nh, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rsp_valid && lat < 50);
        hit = rsp_hit; nh = rsp_nh;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic h;
        logic [3:0] nh;
        int lat;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        check(rsp_hit == 1'b0, "R1 rsp_hit", int'(rsp_hit), 0);
        check(rsp_nh == DEF, "R1 rsp_nh", int'(rsp_nh), int'(DEF));

        // Trie load (R10): idx, prefix, len, has, nh, pos, left, right
        put_node(4'd1, 8'h00, 4'd0, 1'b0, 4'd0, 3'd0, 4'd2, 4'd3);
        put_node(4'd2, 8'h00, 4'd1, 1'b1, 4'd1, 3'd1, 4'd0, 4'd0);
        put_node(4'd3, 8'h80, 4'd2, 1'b1, 4'd2, 3'd3, 4'd4, 4'd5);
        put_node(4'd4, 8'h88, 4'd5, 1'b1, 4'd6, 3'd0, 4'd0, 4'd0);
        put_node(4'd5, 8'hB0, 4'd4, 1'b1, 4'd3, 3'd4, 4'd6, 4'd0);
        put_node(4'd6, 8'hB0, 4'd6, 1'b1, 4'd4, 3'd0, 4'd0, 4'd0);

        for (int i = 0; i < 8; i++) begin
            lookup(VECS[i][12:5], h, nh, lat);
            check(rsp_valid == 1'b1, "R9 response seen", int'(rsp_valid), 1);
            check(h == VECS[i][4], "R4/R5/R6/R7 hit", int'(h), int'(VECS[i][4]));
            check(nh == VECS[i][3:0], "R4/R5/R6/R7 next hop", int'(nh), int'(VECS[i][3:0]));
        end

        // R8: 0xB3 visits root, "10", "1011", "101100" = 4 nodes
        lookup(8'hB3, h, nh, lat);
        check(lat == 4, "R8 latency", lat, 4);
        // R9: pulse lasts one cycle, result held
        @(negedge clk);
        check(rsp_valid == 1'b0, "R9 pulse width", int'(rsp_valid), 0);
        check(rsp_nh == 4'd4 && rsp_hit, "R9 held result", int'(rsp_nh), 4);

        // R2: request during a walk is ignored
        @(negedge clk);
        req_valid = 1'b1; req_addr = 8'hB3;
        @(negedge clk);               // accepted on previous edge
        req_addr = 8'hC0;             // keep valid high while busy
        check(req_ready == 1'b0, "R2 busy ready", int'(req_ready), 0);
        @(negedge clk);
        check(req_ready == 1'b0, "R2 busy ready later", int'(req_ready), 0);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(rsp_nh == 4'd4 && rsp_hit, "R2 first result kept", int'(rsp_nh), 4);
        begin
            int extra = 0;
            repeat (8) begin
                @(negedge clk);
                if (rsp_valid) extra++;
            end
            check(extra == 0, "R2 no response for ignored request", extra, 0);
        end

        // R10 + R8: rewrite node 2 with new hop and a self loop on bit 0
        put_node(4'd2, 8'h00, 4'd1, 1'b1, 4'd7, 3'd1, 4'd2, 4'd0);
        lookup(8'h35, h, nh, lat);
        check(nh == 4'd7 && h, "R10 rewritten next hop", int'(nh), 7);
        check(lat == AW, "R8 visit cap", lat, AW);

        // R3: bit 1 = 1 on 0x75 takes node 2's right child, which is null
        lookup(8'h75, h, nh, lat);
        check(lat == 2, "R3 right branch stop", lat, 2);
        check(nh == 4'd7, "R3 right branch result", int'(nh), 7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule